// File: doc/BRIEF.md
# Non-Volatile Script Download Executor

This block plays back a configuration script held in byte-wide non-volatile memory. A one-cycle load strobe starts a download. The block then fetches the script one byte at a time from address zero upward and interprets each byte as an opcode.

Data opcodes carry a byte count and a 16-bit register address. Their payload bytes are written to consecutive register-map locations, and a checksum byte closes each block. Command opcodes raise single-cycle pulses: a soft update, a calibration start and an output-sync. Condition opcodes are recorded in a small register. An end opcode finishes the run.

A programmable guard interval after each finished run keeps a new load from starting too early. The memory request and the register write both use valid/ready handshakes.

Both interfaces obey the same back-pressure rules:
- The block holds `rd_valid` and `rd_addr` steady until `rd_ready` is seen. At most one read is outstanding at a time. The memory returns exactly one `rsp_valid` beat for each accepted request, and that beat is always consumed.
- The block holds `wr_valid`, `wr_addr` and `wr_data` steady until `wr_ready` is seen. No read is issued while a write waits.

Top module: `nvm_script_runner`

## Requirements
- R1: When `load_req` is high while the block is idle and the guard interval has run out, `busy` rises on the next cycle. Memory is read from address 0 with strictly consecutive addresses.
- R2: An opcode n in 0x00..0x7F is followed by two bytes: the high address byte first, then the low address byte. Next come n+1 payload bytes, written to that address and upward, one per write; the 16-bit address carries across byte boundaries.
- R3: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` stay unchanged, and `rd_valid` stays low.
- R4: Opcode 0x80 gives a one-cycle `upd_pulse`, 0xA0 a one-cycle `cal_pulse` and 0xA1 a one-cycle `sync_pulse`. At most one of the three is high in any cycle.
- R5: An opcode in 0xB0..0xCF sets `cond_id` to the opcode minus 0xB0, so 0xB0 gives the null value 0. `cond_id` returns to 0 when a load is accepted.
- R6: One checksum byte follows each payload. If the sum of the payload bytes and the checksum byte is not 0 modulo 256, `csum_err` is set. It stays set until the next accepted load.
- R7: Opcode 0xFF ends the run: `busy` falls and `done` rises and holds until the next accepted load. The read pointer returns to 0 for the next run.
- R8: A `load_req` is ignored while `busy` is high, and for GUARD_CYCLES cycles after `done` rises.
- R9: Opcode 0xFE and the unassigned opcodes 0x81..0x9F, 0xA2..0xAF and 0xD0..0xFD are one-byte no-operations: no write, no pulse, and `cond_id` unchanged.
- R10: While `rd_valid` is high and `rd_ready` is low, `rd_valid` and `rd_addr` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_req | input | 1 | One-cycle download start strobe |
| rd_valid | output | 1 | Memory read request valid |
| rd_ready | input | 1 | Memory accepts the request |
| rd_addr | output | MEM_AW | Memory byte address |
| rsp_valid | input | 1 | Read data beat valid |
| rsp_data | input | 8 | Read data byte |
| wr_valid | output | 1 | Register write valid |
| wr_ready | input | 1 | Register map accepts the write |
| wr_addr | output | REG_AW | Register write address |
| wr_data | output | 8 | Register write data |
| upd_pulse | output | 1 | Soft update pulse |
| cal_pulse | output | 1 | Calibration start pulse |
| sync_pulse | output | 1 | Output-sync pulse |
| cond_id | output | 5 | Recorded condition number |
| busy | output | 1 | Download in progress |
| done | output | 1 | Last download finished |
| csum_err | output | 1 | Sticky checksum mismatch |

## Verification
The bench builds the block with an 8-bit memory address, 16-bit register addresses and a guard of 8 cycles. These settings keep each run short enough to sweep every command and undefined opcode from 0x80 to 0xFE, one run each. They also allow a sweep of every data count from 1 to 128 bytes, with start addresses that cross a low-byte carry and with every third checksum corrupted. Fixed stall patterns on `rd_ready` and `wr_ready` exercise both back-pressure paths throughout.

// File: rtl/nvm_script_pkg.sv
package nvm_script_pkg;
  localparam int BYTE_W = 8;
  localparam int COND_W = 5;
  localparam int CNT_W  = 7;

  localparam logic [BYTE_W-1:0] OPC_UPD     = 8'h80;
  localparam logic [BYTE_W-1:0] OPC_CAL     = 8'hA0;
  localparam logic [BYTE_W-1:0] OPC_SYNC    = 8'hA1;
  localparam logic [BYTE_W-1:0] OPC_COND_LO = 8'hB0;
  localparam logic [BYTE_W-1:0] OPC_COND_HI = 8'hCF;
  localparam logic [BYTE_W-1:0] OPC_END     = 8'hFF;

  typedef enum logic [2:0] {
    OP_DATA, OP_UPD, OP_CAL, OP_SYNC, OP_COND, OP_END, OP_NOP
  } op_kind_t;

  typedef enum logic [2:0] {
    PH_OPC, PH_AHI, PH_ALO, PH_PAY, PH_CSUM
  } phase_t;

  typedef enum logic [1:0] {
    ST_IDLE, ST_REQ, ST_RSP, ST_WR
  } state_t;
endpackage

// File: rtl/nvm_op_decode.sv
module nvm_op_decode
  import nvm_script_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  output op_kind_t          kind_o,
  output logic [COND_W-1:0] cond_o
);
  always_comb begin
    kind_o = OP_NOP;
    cond_o = '0;
    if (!byte_i[BYTE_W-1]) begin
      kind_o = OP_DATA;
    end else if (byte_i == OPC_UPD) begin
      kind_o = OP_UPD;
    end else if (byte_i == OPC_CAL) begin
      kind_o = OP_CAL;
    end else if (byte_i == OPC_SYNC) begin
      kind_o = OP_SYNC;
    end else if (byte_i >= OPC_COND_LO && byte_i <= OPC_COND_HI) begin
      kind_o = OP_COND;
      cond_o = COND_W'(byte_i - OPC_COND_LO);
    end else if (byte_i == OPC_END) begin
      kind_o = OP_END;
    end
  end
endmodule

// File: rtl/nvm_guard_timer.sv
module nvm_guard_timer #(
  parameter int CYCLES = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic active_o
);
  localparam int W = (CYCLES > 1) ? $clog2(CYCLES + 1) : 1;

  generate
    if (CYCLES == 0) begin : g_none
      assign active_o = 1'b0;
    end else begin : g_cnt
      logic [W-1:0] count_q;

      always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else if (start_i) count_q <= W'(CYCLES);
        else if (count_q != '0) count_q <= count_q - W'(1);
      end

      assign active_o = (count_q != '0);

      assert_guard_arm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> active_o);
    end
  endgenerate
endmodule

// File: rtl/nvm_csum_acc.sv
module nvm_csum_acc
  import nvm_script_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              add_i,
  input  logic [BYTE_W-1:0] add_byte_i,
  input  logic [BYTE_W-1:0] chk_byte_i,
  output logic              bad_o
);
  logic [BYTE_W-1:0] sum_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sum_q <= '0;
    else if (clr_i) sum_q <= '0;
    else if (add_i) sum_q <= sum_q + add_byte_i;
  end

  assign bad_o = ((sum_q + chk_byte_i) != '0);

  assert_sum_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (sum_q == '0));
endmodule

// File: rtl/nvm_script_runner.sv
module nvm_script_runner
  import nvm_script_pkg::*;
#(
  parameter int MEM_AW       = 12,
  parameter int REG_AW       = 16,
  parameter int GUARD_CYCLES = 2500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_req,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [MEM_AW-1:0] rd_addr,
  input  logic              rsp_valid,
  input  logic [BYTE_W-1:0] rsp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [REG_AW-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              upd_pulse,
  output logic              cal_pulse,
  output logic              sync_pulse,
  output logic [COND_W-1:0] cond_id,
  output logic              busy,
  output logic              done,
  output logic              csum_err
);
  localparam int LO_W = BYTE_W;
  localparam int HI_W = REG_AW - LO_W;

  state_t            state_q;
  phase_t            phase_q;
  logic [MEM_AW-1:0] ptr_q;
  logic [REG_AW-1:0] raddr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] wdata_q;
  logic [COND_W-1:0] cond_q;
  logic              done_q, err_q, upd_q, cal_q, sync_q;

  op_kind_t          kind;
  logic [COND_W-1:0] dec_cond;
  logic              guard_active, csum_bad;
  logic              beat, opc_beat, end_hit, start_ok, wr_fire;

  nvm_op_decode u_dec (
    .byte_i (rsp_data),
    .kind_o (kind),
    .cond_o (dec_cond)
  );

  assign beat     = (state_q == ST_RSP) && rsp_valid;
  assign opc_beat = beat && (phase_q == PH_OPC);
  assign end_hit  = opc_beat && (kind == OP_END);
  assign start_ok = (state_q == ST_IDLE) && load_req && !guard_active;
  assign wr_fire  = (state_q == ST_WR) && wr_ready;

  nvm_guard_timer #(.CYCLES(GUARD_CYCLES)) u_guard (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (end_hit),
    .active_o (guard_active)
  );

  nvm_csum_acc u_csum (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (opc_beat),
    .add_i      (wr_fire),
    .add_byte_i (wdata_q),
    .chk_byte_i (rsp_data),
    .bad_o      (csum_bad)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= PH_OPC;
      ptr_q   <= '0;
      raddr_q <= '0;
      cnt_q   <= '0;
      wdata_q <= '0;
      cond_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      upd_q   <= 1'b0;
      cal_q   <= 1'b0;
      sync_q  <= 1'b0;
    end else begin
      upd_q  <= 1'b0;
      cal_q  <= 1'b0;
      sync_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_ok) begin
            state_q <= ST_REQ;
            phase_q <= PH_OPC;
            ptr_q   <= '0;
            cond_q  <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
          end
        end
        ST_REQ: begin
          if (rd_ready) state_q <= ST_RSP;
        end
        ST_RSP: begin
          if (rsp_valid) begin
            ptr_q   <= ptr_q + MEM_AW'(1);
            state_q <= ST_REQ;
            case (phase_q)
              PH_OPC: begin
                case (kind)
                  OP_DATA: begin
                    cnt_q   <= rsp_data[CNT_W-1:0];
                    phase_q <= PH_AHI;
                  end
                  OP_UPD:  upd_q  <= 1'b1;
                  OP_CAL:  cal_q  <= 1'b1;
                  OP_SYNC: sync_q <= 1'b1;
                  OP_COND: cond_q <= dec_cond;
                  OP_END: begin
                    ptr_q   <= '0;
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                  end
                  default: ;
                endcase
              end
              PH_AHI: begin
                raddr_q <= {HI_W'(rsp_data), raddr_q[LO_W-1:0]};
                phase_q <= PH_ALO;
              end
              PH_ALO: begin
                raddr_q <= {raddr_q[REG_AW-1:LO_W], rsp_data};
                phase_q <= PH_PAY;
              end
              PH_PAY: begin
                wdata_q <= rsp_data;
                state_q <= ST_WR;
              end
              default: begin
                if (csum_bad) err_q <= 1'b1;
                phase_q <= PH_OPC;
              end
            endcase
          end
        end
        default: begin
          if (wr_ready) begin
            raddr_q <= raddr_q + REG_AW'(1);
            state_q <= ST_REQ;
            if (cnt_q == '0) phase_q <= PH_CSUM;
            else cnt_q <= cnt_q - CNT_W'(1);
          end
        end
      endcase
    end
  end

  assign rd_valid   = (state_q == ST_REQ);
  assign rd_addr    = ptr_q;
  assign wr_valid   = (state_q == ST_WR);
  assign wr_addr    = raddr_q;
  assign wr_data    = wdata_q;
  assign upd_pulse  = upd_q;
  assign cal_pulse  = cal_q;
  assign sync_pulse = sync_q;
  assign cond_id    = cond_q;
  assign busy       = (state_q != ST_IDLE);
  assign done       = done_q;
  assign csum_err   = err_q;

  assert_start_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && load_req && !guard_active) |=> (busy && rd_addr == '0));
  assert_rd_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !end_hit) |=> (rd_addr == $past(rd_addr) + MEM_AW'(1)));
  assert_wr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
  assert_no_rd_in_wr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !rd_valid);
  assert_pulse_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({upd_pulse, cal_pulse, sync_pulse}));
  assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_pulse || cal_pulse || sync_pulse) |=> !(upd_pulse || cal_pulse || sync_pulse));
  assert_cond_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> (cond_id == '0));
  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (csum_err && !start_ok) |=> csum_err);
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_guard_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && guard_active) |=> !busy);
  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));
endmodule

// File: tb/nvm_script_runner_tb.sv
`timescale 1ns/1ps
module nvm_script_runner_tb_top;
  localparam int MAW = 8;
  localparam int RAW = 16;
  localparam int GC  = 8;
  localparam int WD_LIMIT = 190000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic           rst_n = 1'b0;
  logic           load_req = 1'b0;
  logic           rd_valid, rd_ready = 1'b0;
  logic [MAW-1:0] rd_addr;
  logic           rsp_valid = 1'b0;
  logic [7:0]     rsp_data = 8'h00;
  logic           wr_valid, wr_ready = 1'b0;
  logic [RAW-1:0] wr_addr;
  logic [7:0]     wr_data;
  logic           upd_pulse, cal_pulse, sync_pulse;
  logic [4:0]     cond_id;
  logic           busy, done, csum_err;

  nvm_script_runner #(.MEM_AW(MAW), .REG_AW(RAW), .GUARD_CYCLES(GC)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_req(load_req),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .upd_pulse(upd_pulse), .cal_pulse(cal_pulse), .sync_pulse(sync_pulse),
    .cond_id(cond_id), .busy(busy), .done(done), .csum_err(csum_err)
  );

  logic [7:0]  mem [256];
  logic [15:0] wl_a [256];
  logic [7:0]  wl_d [256];
  int wcount, n_upd, n_cal, n_sync;
  int n_chk = 0, n_bad = 0, cyc = 0;
  int rd_seq_err = 0, hold_err = 0;
  logic [MAW-1:0] rd_next = '0;
  logic acc_pend = 1'b0;
  logic [MAW-1:0] acc_addr;
  logic stall_prev = 1'b0;
  logic [15:0] st_a;
  logic [7:0]  st_d;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= WD_LIMIT) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WD_LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  // memory responder and register sink, driven away from the active edge
  always @(negedge clk) begin
    if (rsp_valid) rsp_valid = 1'b0;
    rd_ready = (cyc % 3) != 0;
    if (acc_pend) begin
      rsp_valid = 1'b1;
      rsp_data  = mem[acc_addr];
      acc_pend  = 1'b0;
    end else if (rd_valid && rd_ready) begin
      if (rd_addr != rd_next) rd_seq_err++;
      rd_next  = rd_addr + MAW'(1);
      acc_pend = 1'b1;
      acc_addr = rd_addr;
    end
    wr_ready = (cyc % 5) != 1;
    if (stall_prev && (!wr_valid || wr_addr != st_a || wr_data != st_d || rd_valid))
      hold_err++;
    stall_prev = wr_valid && !wr_ready;
    st_a = wr_addr;
    st_d = wr_data;
    if (wr_valid && wr_ready) begin
      wl_a[wcount[7:0]] = wr_addr;
      wl_d[wcount[7:0]] = wr_data;
      wcount++;
    end
    if (upd_pulse) n_upd++;
    if (cal_pulse) n_cal++;
    if (sync_pulse) n_sync++;
  end

  task automatic fill_end();
    for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
  endtask

  task automatic clear_log();
    wcount = 0; n_upd = 0; n_cal = 0; n_sync = 0; rd_next = '0;
  endtask

  task automatic run_script();
    clear_log();
    repeat (GC + 3) @(negedge clk);
    load_req = 1'b1;
    @(negedge clk);
    load_req = 1'b0;
    chk(busy == 1'b1, "R1", "busy after load", int'(busy), 1);
    while (busy) @(negedge clk);
  endtask

  logic [15:0] base;
  logic [7:0]  sum, pv, cs;
  bit          bad_cs;

  initial begin
    fill_end();
    repeat (4) @(negedge clk);
    chk({busy, done, csum_err, rd_valid, wr_valid} == 5'b0, "R7", "reset status",
        int'({busy, done, csum_err, rd_valid, wr_valid}), 0);
    chk(cond_id == 5'd0, "R5", "reset cond", int'(cond_id), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // mixed command script
    mem[0] = 8'h80; mem[1] = 8'hA0; mem[2] = 8'hA1; mem[3] = 8'hB3;
    mem[4] = 8'h01; mem[5] = 8'h00; mem[6] = 8'h10; mem[7] = 8'hAA; mem[8] = 8'h55;
    mem[9] = 8'h01; mem[10] = 8'hFE; mem[11] = 8'hFF;
    run_script();
    chk(done == 1'b1, "R7", "done after end", int'(done), 1);
    chk(n_upd == 1 && n_cal == 1 && n_sync == 1, "R4", "pulse counts",
        n_upd * 256 + n_cal * 16 + n_sync, 273);
    chk(cond_id == 5'd3, "R5", "cond after 0xB3", int'(cond_id), 3);
    chk(wcount == 2, "R2", "write count", wcount, 2);
    chk(wl_a[0] == 16'h0010 && wl_d[0] == 8'hAA, "R2", "write0",
        int'({wl_a[0], wl_d[0]}), 'h0010AA);
    chk(wl_a[1] == 16'h0011 && wl_d[1] == 8'h55, "R2", "write1",
        int'({wl_a[1], wl_d[1]}), 'h001155);
    chk(csum_err == 1'b0, "R6", "good checksum", int'(csum_err), 0);

    // sweep of every single-byte opcode 0x80..0xFE
    for (int v = 'h80; v <= 'hFE; v++) begin
      fill_end();
      mem[0] = 8'(v);
      run_script();
      chk(n_upd == ((v == 'h80) ? 1 : 0) && n_cal == ((v == 'hA0) ? 1 : 0) &&
          n_sync == ((v == 'hA1) ? 1 : 0), "R4", $sformatf("pulses op %0h", v),
          n_upd * 256 + n_cal * 16 + n_sync,
          ((v == 'h80) ? 256 : 0) + ((v == 'hA0) ? 16 : 0) + ((v == 'hA1) ? 1 : 0));
      chk(cond_id == ((v >= 'hB0 && v <= 'hCF) ? 5'(v - 'hB0) : 5'd0), "R5",
          $sformatf("cond op %0h", v), int'(cond_id),
          (v >= 'hB0 && v <= 'hCF) ? v - 'hB0 : 0);
      chk(wcount == 0 && done == 1'b1, "R9", $sformatf("no-op/no write op %0h", v),
          wcount, 0);
    end

    // sweep of every data length
    for (int n = 0; n < 128; n++) begin
      fill_end();
      base = 16'h12F0 + 16'(n);
      bad_cs = (n % 3) == 0;
      mem[0] = 8'(n); mem[1] = base[15:8]; mem[2] = base[7:0];
      sum = 8'h00;
      for (int i = 0; i <= n; i++) begin
        pv = 8'(n * 7 + i * 13 + 5);
        mem[3 + i] = pv;
        sum = sum + pv;
      end
      cs = 8'h00 - sum + (bad_cs ? 8'h01 : 8'h00);
      mem[4 + n] = cs;
      run_script();
      chk(wcount == n + 1, "R2", $sformatf("count len %0d", n + 1), wcount, n + 1);
      for (int i = 0; i <= n; i++) begin
        pv = 8'(n * 7 + i * 13 + 5);
        chk(wl_a[i] == base + 16'(i) && wl_d[i] == pv, "R2",
            $sformatf("payload n=%0d i=%0d", n, i),
            int'({wl_a[i], wl_d[i]}), int'({base + 16'(i), pv}));
      end
      chk(csum_err == bad_cs, "R6", $sformatf("csum flag n=%0d", n),
          int'(csum_err), int'(bad_cs));
    end

    // sticky flag over a later good block, cleared by the next load
    fill_end();
    mem[0] = 8'h00; mem[1] = 8'h00; mem[2] = 8'h20; mem[3] = 8'h11; mem[4] = 8'h00;
    mem[5] = 8'h00; mem[6] = 8'h00; mem[7] = 8'h21; mem[8] = 8'h22; mem[9] = 8'hDE;
    run_script();
    chk(csum_err == 1'b1, "R6", "sticky over good block", int'(csum_err), 1);
    fill_end();
    run_script();
    chk(csum_err == 1'b0 && wcount == 0, "R6", "cleared by new load", int'(csum_err), 0);

    // guard interval right after done, then load during a run
    @(negedge clk);
    load_req = 1'b1;
    @(negedge clk);
    load_req = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b1, "R8", "load inside guard", int'(busy), 0);
    fill_end();
    mem[0] = 8'd20; mem[1] = 8'h40; mem[2] = 8'h00;
    for (int i = 3; i < 24; i++) mem[i] = 8'h00;
    mem[24] = 8'h00;
    clear_log();
    repeat (GC + 3) @(negedge clk);
    load_req = 1'b1;
    @(negedge clk);
    load_req = 1'b0;
    repeat (30) @(negedge clk);
    load_req = 1'b1;
    @(negedge clk);
    load_req = 1'b0;
    while (busy) @(negedge clk);
    chk(wcount == 21, "R8", "load while busy ignored", wcount, 21);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R7", "stays idle after end", int'(busy), 0);

    chk(rd_seq_err == 0, "R1", "sequential reads from 0 (R7 pointer reset)", rd_seq_err, 0);
    chk(hold_err == 0, "R3", "write held under stall", hold_err, 0);
    chk(rd_seq_err == 0, "R10", "read request held", rd_seq_err, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule